// File: doc/BRIEF.md
# Receive FIFO with error lock

This block buffers characters coming out of a serial receiver. Each character enters together with four status bits, and the status travels in a second FIFO that shares the pointers of the data FIFO, so the head of both always belongs to the same character. The head character and its status are shown at the read port, and a read strobe removes the head. A DMA request output follows data availability, so a DMA engine can drain the FIFO without processor help.

An interrupt mode input selects how characters with error status are treated. In the two lock modes (first-character-or-special and special-only), an error character at the head withholds the DMA request and raises the special-condition interrupt instead. The processor reads that character, which does not remove it: the data and status FIFOs freeze, so the cause of the error stays visible for as long as software needs. An error-reset strobe then discards the locked character and releases the FIFO. In the other modes, error characters flow through like any other data.

Top module: `rxq_errlock`

## Requirements
- R1: After reset the FIFO is empty: `avail_o`, `dma_req_o` and `spec_irq_o` are all 0.
- R2: When no lock is active and the head character is not held, `dma_req_o` equals `avail_o` (1 whenever at least one character is stored).
- R3: In mode 1 or mode 3 of `mode_i`, a head character whose status is special (any of the four status bits set) drives `dma_req_o` to 0 and `spec_irq_o` to 1.
- R4: In mode 1 or 3, a read of a special head returns it but does not remove it. Once that read has happened the FIFO is locked. Further reads do not remove anything, and `rd_data_o` and `rd_stat_o` keep their value. `dma_req_o` stays 0 and `spec_irq_o` stays 1 until an error reset.
- R5: `err_reset_i` while locked discards the head entry and clears the lock; a read in the same cycle is ignored. While not locked, `err_reset_i` does nothing and any read in that cycle is ignored too.
- R6: In mode 0 or mode 2, special characters raise a DMA request and are removed by a read like ordinary data.
- R7: A push into a full FIFO (with no removal in the same cycle) overwrites the newest entry and sets its overrun bit (status bit 1). A push in the same cycle as a removal from a full FIFO is stored normally.
- R8: Characters leave in arrival order, the FIFO holds DEPTH entries (3 by default), and pushes are accepted while the FIFO is locked.
- R9: Status encoding on `push_stat_i` and `rd_stat_o`: bit 0 parity error, bit 1 overrun, bit 2 framing error, bit 3 end of frame. Each entry keeps the status it was pushed with, apart from the overrun bit that R7 sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_i | input | 1 | Push one received character |
| push_data_i | input | DATA_W | Received character |
| push_stat_i | input | 4 | Status of the received character (R9 encoding) |
| rd_i | input | 1 | Read strobe; removes the head unless held or locked |
| mode_i | input | 2 | Interrupt mode; 1 and 3 are lock modes |
| err_reset_i | input | 1 | Error-reset command strobe |
| rd_data_o | output | DATA_W | Head character |
| rd_stat_o | output | 4 | Head status |
| avail_o | output | 1 | At least one character stored |
| dma_req_o | output | 1 | DMA request |
| spec_irq_o | output | 1 | Special-condition interrupt |

## Verification
Two pairs of functions can meet in one cycle: a push into a full FIFO together with a removal, and an error reset together with a read strobe. A bench model that applies the removal before the push, and the error reset before the read, predicts every output after each cycle. Random stimulus pushes often enough to keep the FIFO near full while reads and resets arrive at random. Directed sequences add the overwrite case, the locked double read and a reset on an unlocked FIFO, and each is judged against literal expected values.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
   localparam int STAT_W  = 4;
   localparam int ST_PAR  = 0;
   localparam int ST_OVR  = 1;
   localparam int ST_FRM  = 2;
   localparam int ST_EOF  = 3;

   typedef logic [STAT_W-1:0] rx_stat_t;

   function automatic logic stat_is_special(rx_stat_t s, bit with_eof);
      logic r;
      r = s[ST_PAR] | s[ST_OVR] | s[ST_FRM];
      if (with_eof) r = r | s[ST_EOF];
      return r;
   endfunction
endpackage

// File: rtl/rxq_ptrs.sv
module rxq_ptrs #(
   parameter int DEPTH = 3
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          push,
   input  logic                          pop,
   output logic                          we,
   output logic [$clog2(DEPTH)-1:0]      waddr,
   output logic [$clog2(DEPTH)-1:0]      raddr,
   output logic [$clog2(DEPTH+1)-1:0]    count,
   output logic                          overrun
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH+1);
   localparam logic [AW-1:0] LAST = AW'(DEPTH-1);
   localparam logic [CW-1:0] FULL = CW'(DEPTH);

   if (DEPTH < 2) begin : g_bad_depth
      $error("rxq_ptrs: DEPTH must be at least 2");
   end

   logic [AW-1:0] wr_q, rd_q;
   logic          full_eff, push_ok;

   function automatic logic [AW-1:0] inc(logic [AW-1:0] p);
      return (p == LAST) ? '0 : p + AW'(1);
   endfunction

   function automatic logic [AW-1:0] dec(logic [AW-1:0] p);
      return (p == '0) ? LAST : p - AW'(1);
   endfunction

   always_comb begin
      full_eff = (count == FULL) && !pop;
      push_ok  = push && !full_eff;
      overrun  = push && full_eff;
      we       = push;
      waddr    = full_eff ? dec(wr_q) : wr_q;
      raddr    = rd_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_q  <= '0;
         rd_q  <= '0;
         count <= '0;
      end else begin
         if (pop)     rd_q <= inc(rd_q);
         if (push_ok) wr_q <= inc(wr_q);
         count <= count + CW'(push_ok) - CW'(pop);
      end
   end

   assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      count <= FULL);
   assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> count != '0);
   assert_overrun_keeps_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |=> count == FULL);
endmodule

// File: rtl/rxq_mem.sv
module rxq_mem #(
   parameter int W     = 8,
   parameter int DEPTH = 3
) (
   input  logic                     clk,
   input  logic                     we,
   input  logic [$clog2(DEPTH)-1:0] waddr,
   input  logic [W-1:0]             wdata,
   input  logic [$clog2(DEPTH)-1:0] raddr,
   output logic [W-1:0]             rdata
);
   logic [W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      for (int i = 0; i < DEPTH; i++) begin
         if (we && waddr == i[$clog2(DEPTH)-1:0]) mem[i] <= wdata;
      end
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/rxq_lock.sv
module rxq_lock #(
   parameter logic [3:0] LOCK_MASK = 4'b1010
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] mode,
   input  logic       avail,
   input  logic       head_err,
   input  logic       rd,
   input  logic       err_rst,
   output logic       pop,
   output logic       locked,
   output logic       dma_req,
   output logic       spec_irq
);
   logic lock_q, lock_mode, hold, rd_ok;

   always_comb begin
      lock_mode = LOCK_MASK[mode];
      hold      = lock_mode && avail && head_err;
      rd_ok     = rd && avail && !lock_q && !err_rst;
      pop       = err_rst ? lock_q : (rd_ok && !hold);
      dma_req   = avail && !hold && !lock_q;
      spec_irq  = hold || lock_q;
      locked    = lock_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)             lock_q <= 1'b0;
      else if (err_rst)       lock_q <= 1'b0;
      else if (rd_ok && hold) lock_q <= 1'b1;
   end

   assert_lock_persists_R4: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q && !err_rst |=> lock_q);
   assert_unlock_after_reset_R5: assert property (@(posedge clk) disable iff (!rst_n)
      err_rst |=> !lock_q);
   assert_lock_needs_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lock_q) |-> $past(rd));
endmodule

// File: rtl/rxq_errlock.sv
module rxq_errlock #(
   parameter int         DATA_W      = 8,
   parameter int         DEPTH       = 3,
   parameter logic [3:0] LOCK_MASK   = 4'b1010,
   parameter bit         EOF_SPECIAL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_i,
   input  logic [DATA_W-1:0] push_data_i,
   input  logic [3:0]        push_stat_i,
   input  logic              rd_i,
   input  logic [1:0]        mode_i,
   input  logic              err_reset_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic [3:0]        rd_stat_o,
   output logic              avail_o,
   output logic              dma_req_o,
   output logic              spec_irq_o
);
   import rxq_pkg::*;

   localparam int AW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH+1);

   if (DATA_W < 1) begin : g_bad_width
      $error("rxq_errlock: DATA_W must be positive");
   end

   logic          we, overrun, pop, head_err, locked;
   logic [AW-1:0] waddr, raddr;
   logic [CW-1:0] count;
   rx_stat_t      stat_w, stat_r;

   rxq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
      .clk(clk), .rst_n(rst_n), .push(push_i), .pop(pop),
      .we(we), .waddr(waddr), .raddr(raddr), .count(count), .overrun(overrun)
   );

   always_comb begin
      stat_w = push_stat_i;
      if (overrun) stat_w[ST_OVR] = 1'b1;
   end

   rxq_mem #(.W(DATA_W), .DEPTH(DEPTH)) u_data (
      .clk(clk), .we(we), .waddr(waddr), .wdata(push_data_i),
      .raddr(raddr), .rdata(rd_data_o)
   );

   rxq_mem #(.W(STAT_W), .DEPTH(DEPTH)) u_stat (
      .clk(clk), .we(we), .waddr(waddr), .wdata(stat_w),
      .raddr(raddr), .rdata(stat_r)
   );

   assign rd_stat_o = stat_r;
   assign avail_o   = (count != '0);

   if (EOF_SPECIAL) begin : g_eof_special
      assign head_err = stat_is_special(stat_r, 1'b1);
   end else begin : g_eof_plain
      assign head_err = stat_is_special(stat_r, 1'b0);
   end

   rxq_lock #(.LOCK_MASK(LOCK_MASK)) u_lock (
      .clk(clk), .rst_n(rst_n), .mode(mode_i), .avail(avail_o),
      .head_err(head_err), .rd(rd_i), .err_rst(err_reset_i),
      .pop(pop), .locked(locked), .dma_req(dma_req_o), .spec_irq(spec_irq_o)
   );

   assert_locked_head_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
      locked && !err_reset_i |=> $stable(rd_data_o) && $stable(rd_stat_o));
   assert_dma_needs_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req_o |-> avail_o);
   assert_irq_blocks_dma_R3: assert property (@(posedge clk) disable iff (!rst_n)
      spec_irq_o |-> !dma_req_o);
   assert_reset_empty_R1: assert property (@(posedge clk)
      !rst_n |=> !avail_o && !spec_irq_o);
endmodule

// File: tb/rxq_errlock_test.sv
module rxq_errlock_test;
   localparam int DEPTH = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       push_i = 1'b0;
   logic [7:0] push_data_i = '0;
   logic [3:0] push_stat_i = '0;
   logic       rd_i = 1'b0;
   logic [1:0] mode_i = 2'd2;
   logic       err_reset_i = 1'b0;
   logic [7:0] rd_data_o;
   logic [3:0] rd_stat_o;
   logic       avail_o, dma_req_o, spec_irq_o;

   rxq_errlock uut (
      .clk(clk), .rst_n(rst_n), .push_i(push_i), .push_data_i(push_data_i),
      .push_stat_i(push_stat_i), .rd_i(rd_i), .mode_i(mode_i),
      .err_reset_i(err_reset_i), .rd_data_o(rd_data_o), .rd_stat_o(rd_stat_o),
      .avail_o(avail_o), .dma_req_o(dma_req_o), .spec_irq_o(spec_irq_o)
   );

   always #10 clk = ~clk;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  done = 0;

   logic [7:0] qd [DEPTH];
   logic [3:0] qs [DEPTH];
   int         cnt = 0;
   bit         lock = 0;

   task automatic chk(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic bit lock_mode(logic [1:0] m);
      return (m == 2'd1) || (m == 2'd3);
   endfunction

   function automatic bit held();
      return lock_mode(mode_i) && cnt > 0 && qs[0] != 4'd0;
   endfunction

   function automatic void model_pop();
      for (int i = 0; i < DEPTH-1; i++) begin
         qd[i] = qd[i+1];
         qs[i] = qs[i+1];
      end
      cnt--;
   endfunction

   task automatic step(bit p, logic [7:0] d, logic [3:0] s, bit r, bit e, logic [1:0] m);
      push_i = p; push_data_i = d; push_stat_i = s;
      rd_i = r; err_reset_i = e; mode_i = m;
      if (e) begin
         if (lock) begin model_pop(); lock = 0; end
      end else if (r && cnt > 0 && !lock) begin
         if (held()) lock = 1;
         else model_pop();
      end
      if (p) begin
         if (cnt == DEPTH) begin
            qd[cnt-1] = d;
            qs[cnt-1] = s | 4'b0010;
         end else begin
            qd[cnt] = d; qs[cnt] = s; cnt++;
         end
      end
      @(negedge clk);
      push_i = 0; rd_i = 0; err_reset_i = 0;
      chk("R8 avail", int'(avail_o), int'(cnt > 0));
      chk(held() ? "R3 dma" : "R2 dma", int'(dma_req_o), int'(cnt > 0 && !held() && !lock));
      chk("R3 irq", int'(spec_irq_o), int'(held() || lock));
      if (cnt > 0) begin
         chk("R8 data", int'(rd_data_o), int'(qd[0]));
         chk("R9 stat", int'(rd_stat_o), int'(qs[0]));
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [1:0] m;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 avail", int'(avail_o), 0);
      chk("R1 dma", int'(dma_req_o), 0);
      chk("R1 irq", int'(spec_irq_o), 0);

      // R7 overflow in mode 0
      step(1, 8'h11, 4'h0, 0, 0, 2'd0);
      step(1, 8'h22, 4'h0, 0, 0, 2'd0);
      step(1, 8'h33, 4'h0, 0, 0, 2'd0);
      step(1, 8'h44, 4'h8, 0, 0, 2'd0);
      step(0, 8'h00, 4'h0, 1, 0, 2'd0);
      step(0, 8'h00, 4'h0, 1, 0, 2'd0);
      chk("R7 overwritten data", int'(rd_data_o), 32'h44);
      chk("R7 overrun bit", int'(rd_stat_o), 32'hA);
      // R7 push plus removal when full: stored normally
      step(1, 8'h55, 4'h0, 0, 0, 2'd0);
      step(1, 8'h66, 4'h0, 0, 0, 2'd0);
      step(1, 8'h77, 4'h0, 1, 0, 2'd0);
      step(0, 8'h00, 4'h0, 1, 0, 2'd0);
      step(0, 8'h00, 4'h0, 1, 0, 2'd0);
      chk("R7 no overrun on simultaneous pop", int'(rd_stat_o), 0);
      chk("R7 last data", int'(rd_data_o), 32'h77);
      step(0, 8'h00, 4'h0, 1, 0, 2'd0);

      // R6 mode 2: error char passes
      step(1, 8'h5A, 4'h1, 0, 0, 2'd2);
      chk("R6 dma on error char", int'(dma_req_o), 1);
      step(0, 8'h00, 4'h0, 1, 0, 2'd2);
      chk("R6 error char removed", int'(avail_o), 0);

      // R3 R4 R5 lock in mode 1
      step(1, 8'hE1, 4'h4, 0, 0, 2'd1);
      chk("R3 dma held", int'(dma_req_o), 0);
      chk("R3 irq raised", int'(spec_irq_o), 1);
      step(1, 8'h0B, 4'h0, 1, 0, 2'd1);
      chk("R4 head kept", int'(rd_data_o), 32'hE1);
      step(0, 8'h00, 4'h0, 1, 0, 2'd1);
      chk("R4 second read same status", int'(rd_stat_o), 32'h4);
      chk("R4 dma stays off", int'(dma_req_o), 0);
      step(0, 8'h00, 4'h0, 1, 1, 2'd1);
      chk("R5 head after reset", int'(rd_data_o), 32'h0B);
      chk("R5 dma resumes", int'(dma_req_o), 1);
      chk("R5 irq cleared", int'(spec_irq_o), 0);
      // R5 reset while unlocked does nothing
      step(0, 8'h00, 4'h0, 1, 1, 2'd3);
      chk("R5 unlocked reset ignored", int'(rd_data_o), 32'h0B);
      step(0, 8'h00, 4'h0, 1, 0, 2'd3);
      chk("R8 drained", int'(avail_o), 0);

      // random phase
      m = 2'd1;
      for (int i = 0; i < 4000; i++) begin
         bit p, r, e;
         logic [3:0] s;
         if ($urandom_range(0, 49) == 0) m = 2'($urandom_range(0, 3));
         p = $urandom_range(0, 99) < 55;
         r = $urandom_range(0, 99) < 40;
         e = $urandom_range(0, 99) < 8;
         s = ($urandom_range(0, 3) == 0) ? 4'($urandom_range(1, 15)) : 4'h0;
         step(p, 8'($urandom), s, r, e, m);
      end

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule